// File: doc/BRIEF.md
# Vertical Display Timing Generator

This block produces the vertical half of a raster display's timing. It never sees pixels or pixel clocks. It counts whole rasters, advancing on a one-cycle line-start strobe from the horizontal timing logic. From that count it drives four things:

- vertical sync
- vertical display enable
- the current raster index
- one-cycle pulses marking the start of each field and each frame

Four programmable quantities control the timing: the vertical total, the active display length, the sync start position and the sync width. Each is written to the register as its value minus one. A small byte-wide write port sets them, and a combinational read port returns them.

Register writes go to a working copy. The timing logic uses a separate active copy, which is refreshed from the working copy only when a frame begins. The interlace mode pin is sampled at the same moment. Because of this, software can reprogram the block at any time without producing a malformed frame.

In interlaced mode each field runs for the programmed total plus one and a half rasters. The even field advances on the line strobe and ends on the half-line strobe. The odd field does the reverse, so all of its vertical events fall half a line later.

Top module: `vtiming_gen`

## Requirements
- R1: While reset is held, and afterwards until the first line strobe, `raster` is 0, `field` is 0, and `vsync`, `vde`, `field_start` and `frame_start` are all 0.
- R2: In progressive mode with active total T, `raster` steps 0,1,…,T on successive line strobes, then returns to 0. A frame therefore lasts T+1 rasters. `raster`, `vsync` and `vde` change in the clock cycle after the strobe that moves them.
- R3: `vde` is high exactly while `raster` is at most the active display value D, giving D+1 displayed rasters when D ≤ T.
- R4: `vsync` is high while `raster` lies from P through P+W, where P is the position value and W is the width value. This is W+1 rasters starting at raster P, which is the (P+1)th raster after display start. Rasters above the frame's last raster are never reached.
- R5: Register byte offsets are as follows. 0x0F holds the width in bits 6:0. The total is a pair of bytes: low at 0x12, high at 0x13. The position pair is 0x14/0x15 and the display pair is 0x16/0x17. Each high byte holds value bits 11:8 in its bits 3:0. Reserved bits (bit 7 of 0x0F, bits 7:4 of each high byte) ignore writes and read as 0. Unmapped offsets read as 0.
- R6: A register write changes neither the current frame's timing nor the outputs. It takes effect at the next frame start.
- R7: In interlaced mode with total T, the even field advances on line strobes through raster T. It then spends half a line in raster T+1 and ends on the next half-line strobe. The odd field advances on half-line strobes and ends on the line strobe in its raster T+1. `field` is 0 in the even field and 1 in the odd field, and a frame spans 2T+3 lines.
- R8: `field_start` pulses for one cycle, with `raster` at 0, at every field start. `frame_start` pulses together with it only when a frame begins. In progressive mode that is every field; in interlaced mode it is only when the even field begins.
- R9: In progressive mode the half-line strobe has no effect and `field` stays 0.
- R10: The `interlace` pin is sampled only at a frame start. Changing it mid-frame has no effect until the next `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_strb | input | 1 | One-cycle pulse at each raster start |
| half_strb | input | 1 | One-cycle pulse at each mid-raster point |
| interlace | input | 1 | 1 selects interlaced mode, sampled at frame start |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 8 | Register read data (combinational) |
| vsync | output | 1 | Vertical sync, active high |
| vde | output | 1 | Vertical display enable |
| raster | output | 13 | Current raster index within the field |
| field | output | 1 | 0 in the even field, 1 in the odd field |
| field_start | output | 1 | One-cycle pulse at each field start |
| frame_start | output | 1 | One-cycle pulse at each frame start |

## Verification
A corrupted raster counter shows on `raster` in the very cycle after the next strobe, and on `vde` or `vsync` as soon as the count crosses a programmed boundary. A stale or prematurely loaded active copy of the registers changes the measured frame length, active length or sync placement within one frame of the write. A wrong field bit swaps which strobe advances the count. It therefore surfaces within half a line as rasters moving on the wrong strobe, and within one field as a missing or extra `frame_start`.

// File: rtl/vtiming_gen.sv
module vtiming_gen #(
  parameter int VAL_W  = 12,
  parameter int SW_W   = 7,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_SW   = 'h0F,
  parameter logic [ADDR_W-1:0] A_TOT  = 'h12,
  parameter logic [ADDR_W-1:0] A_POS  = 'h14,
  parameter logic [ADDR_W-1:0] A_DISP = 'h16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_strb,
  input  logic              half_strb,
  input  logic              interlace,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              vsync,
  output logic              vde,
  output logic [VAL_W:0]    raster,
  output logic              field,
  output logic              field_start,
  output logic              frame_start
);

  localparam int RW = VAL_W + 1;
  localparam logic [15:0] VMASK = 16'((32'd1 << VAL_W) - 1);
  localparam logic [7:0]  SMASK = 8'((32'd1 << SW_W) - 1);
  localparam logic [ADDR_W-1:0] A_TOT_H  = A_TOT + 1'b1;
  localparam logic [ADDR_W-1:0] A_POS_H  = A_POS + 1'b1;
  localparam logic [ADDR_W-1:0] A_DISP_H = A_DISP + 1'b1;

  // working copies, written by software
  logic [7:0]  r_sw;
  logic [15:0] r_tot, r_pos, r_disp;

  // active copies, refreshed at frame start
  logic [VAL_W-1:0] s_tot, s_pos, s_disp;
  logic [SW_W-1:0]  s_sw;
  logic             s_il;

  logic [RW-1:0] row_q;
  logic          field_q, vs_q, de_q, fs_q, frs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_sw <= '0; r_tot <= '0; r_pos <= '0; r_disp <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_SW)     r_sw         <= wr_data & SMASK;
      if (wr_addr == A_TOT)    r_tot[7:0]   <= wr_data & VMASK[7:0];
      if (wr_addr == A_TOT_H)  r_tot[15:8]  <= wr_data & VMASK[15:8];
      if (wr_addr == A_POS)    r_pos[7:0]   <= wr_data & VMASK[7:0];
      if (wr_addr == A_POS_H)  r_pos[15:8]  <= wr_data & VMASK[15:8];
      if (wr_addr == A_DISP)   r_disp[7:0]  <= wr_data & VMASK[7:0];
      if (wr_addr == A_DISP_H) r_disp[15:8] <= wr_data & VMASK[15:8];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_SW:     rd_data = r_sw;
      A_TOT:    rd_data = r_tot[7:0];
      A_TOT_H:  rd_data = r_tot[15:8];
      A_POS:    rd_data = r_pos[7:0];
      A_POS_H:  rd_data = r_pos[15:8];
      A_DISP:   rd_data = r_disp[7:0];
      A_DISP_H: rd_data = r_disp[15:8];
      default:  rd_data = '0;
    endcase
  end

  // the odd field runs half a line behind: the strobes swap roles
  wire adv     = field_q ? half_strb : line_strb;
  wire fin     = field_q ? line_strb : half_strb;
  wire last    = row_q == {1'b0, s_tot};
  wire in_half = s_il && (row_q == {1'b0, s_tot} + 1'b1);
  wire fld_end = s_il ? (in_half && fin) : (adv && last);
  wire frm_end = fld_end && (!s_il || field_q);
  wire step    = adv && !in_half && !fld_end;
  wire tick    = fld_end || step;

  wire [VAL_W-1:0] pos_n  = frm_end ? r_pos[VAL_W-1:0]  : s_pos;
  wire [VAL_W-1:0] disp_n = frm_end ? r_disp[VAL_W-1:0] : s_disp;
  wire [SW_W-1:0]  sw_n   = frm_end ? r_sw[SW_W-1:0]    : s_sw;
  wire [RW-1:0]    row_n  = fld_end ? '0 : row_q + 1'b1;
  wire [RW-1:0]    ofs    = row_n - {1'b0, pos_n};
  wire             vs_n   = (row_n >= {1'b0, pos_n}) && (ofs <= RW'(sw_n));
  wire             de_n   = row_n <= {1'b0, disp_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q <= '0; field_q <= 1'b0; vs_q <= 1'b0; de_q <= 1'b0;
      fs_q <= 1'b0; frs_q <= 1'b0;
      s_tot <= '0; s_pos <= '0; s_disp <= '0; s_sw <= '0; s_il <= 1'b0;
    end else begin
      fs_q  <= fld_end;
      frs_q <= frm_end;
      if (tick) begin
        row_q <= row_n;
        vs_q  <= vs_n;
        de_q  <= de_n;
      end
      if (fld_end) field_q <= !frm_end;
      if (frm_end) begin
        s_tot  <= r_tot[VAL_W-1:0];
        s_pos  <= pos_n;
        s_disp <= disp_n;
        s_sw   <= sw_n;
        s_il   <= interlace;
      end
    end
  end

  assign raster      = row_q;
  assign field       = field_q;
  assign vsync       = vs_q;
  assign vde         = de_q;
  assign field_start = fs_q;
  assign frame_start = frs_q;

  assert_start_row_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |-> row_q == '0);
  assert_frame_has_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frs_q |-> fs_q && !field_q);
  assert_row_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    row_q <= {1'b0, s_tot} + RW'(s_il));
  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frs_q |-> ($stable(s_tot) && $stable(s_pos) && $stable(s_disp) && $stable(s_sw) && $stable(s_il)));
  assert_prog_field_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !s_il |-> !field_q);
  assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == A_TOT_H || rd_addr == A_POS_H || rd_addr == A_DISP_H) |-> (rd_data & ~VMASK[15:8]) == 8'h00);

endmodule

// File: tb/vtiming_gen_bench.sv
module vtiming_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LP = 8;

  logic clk = 0, rst_n = 0;
  logic ls = 0, hs = 0, il = 0, wr_en = 0;
  logic [7:0] wr_addr = 0, wr_data = 0, rd_addr = 0;
  logic [7:0] rd_data;
  logic vsync, vde, field, fs, frs;
  logic [12:0] raster;

  vtiming_gen u_vtiming_gen (
    .clk(clk), .rst_n(rst_n), .line_strb(ls), .half_strb(hs), .interlace(il),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .vsync(vsync), .vde(vde), .raster(raster), .field(field),
    .field_start(fs), .frame_start(frs));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference
  int m_row, m_fld, m_il, m_tot, m_pos, m_disp, m_sw, m_vs, m_de, m_fs, m_frs;
  int w_tot, w_pos, w_disp, w_sw;
  int sa, sf;
  bit moved;

  task automatic close_field();
    m_fs = 1;
    m_row = 0;
    if (!m_il || m_fld == 1) begin
      m_fld = 0; m_frs = 1; m_il = il;
      m_tot = w_tot; m_pos = w_pos; m_disp = w_disp; m_sw = w_sw;
    end else m_fld = 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_row = 0; m_fld = 0; m_il = 0; m_tot = 0; m_pos = 0; m_disp = 0; m_sw = 0;
      m_vs = 0; m_de = 0; m_fs = 0; m_frs = 0;
      w_tot = 0; w_pos = 0; w_disp = 0; w_sw = 0;
    end else begin
      m_fs = 0; m_frs = 0; moved = 0;
      sa = m_fld ? int'(hs) : int'(ls);
      sf = m_fld ? int'(ls) : int'(hs);
      if (m_il && m_row == m_tot + 1) begin
        if (sf) begin close_field(); moved = 1; end
      end else if (sa) begin
        if (!m_il && m_row == m_tot) close_field();
        else m_row++;
        moved = 1;
      end
      if (moved) begin
        m_de = (m_row <= m_disp);
        m_vs = (m_row >= m_pos && m_row <= m_pos + m_sw);
      end
      if (wr_en) case (wr_addr)
        8'h0F: w_sw = wr_data & 8'h7F;
        8'h12: w_tot = (w_tot & 'hF00) | wr_data;
        8'h13: w_tot = (w_tot & 'hFF) | ((wr_data & 8'h0F) << 8);
        8'h14: w_pos = (w_pos & 'hF00) | wr_data;
        8'h15: w_pos = (w_pos & 'hFF) | ((wr_data & 8'h0F) << 8);
        8'h16: w_disp = (w_disp & 'hF00) | wr_data;
        8'h17: w_disp = (w_disp & 'hFF) | ((wr_data & 8'h0F) << 8);
        default: ;
      endcase
    end
  end

  // comparison, per-frame measurement, strobe generation
  bit run = 0, prog_watch = 0, r10_watch = 0, valid = 0;
  int ph = 0, frame_no = 0, last_lines = 0;
  int ln = 0, ev = 0, de_cnt = 0, vs_cnt = 0, vs_row = -1, fcnt = 0, vs_prev = 0;
  int f_tot, f_il, f_disp, f_pos, f_sw;
  int prog_fld_hi = 0, r10_viol = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(raster) == m_row, "R2", "raster", int'(raster), m_row);
      chk(int'(vde) == m_de, "R3", "vde", int'(vde), m_de);
      chk(int'(vsync) == m_vs, "R4", "vsync", int'(vsync), m_vs);
      chk(int'(field) == m_fld, "R7", "field", int'(field), m_fld);
      chk(int'(fs) == m_fs && int'(frs) == m_frs, "R8", "start pulses", {int'(fs), int'(frs)}, {m_fs, m_frs});
      if (prog_watch && field) prog_fld_hi++;
      if (r10_watch && field) r10_viol++;
      if (frs) begin
        if (valid) begin
          if (f_il) begin
            chk(ev == 4*f_tot + 6, "R7", "half-lines per frame", ev, 4*f_tot + 6);
            chk(fcnt == 2, "R8", "fields per frame", fcnt, 2);
          end else begin
            automatic int ev_vs = 0;
            for (int r = 0; r <= f_tot; r++) if (r >= f_pos && r <= f_pos + f_sw) ev_vs++;
            chk(ln == f_tot + 1, "R2 R9", "lines per frame", ln, f_tot + 1);
            chk(de_cnt == ((f_disp < f_tot) ? f_disp : f_tot) + 1, "R3", "active rasters", de_cnt,
                ((f_disp < f_tot) ? f_disp : f_tot) + 1);
            chk(vs_cnt == ev_vs, "R4", "sync rasters", vs_cnt, ev_vs);
            if (f_pos <= f_tot) chk(vs_row == f_pos, "R4", "sync start raster", vs_row, f_pos);
          end
        end
        valid = 1;
        last_lines = ln;
        frame_no++;
        ln = 0; ev = 0; de_cnt = 0; vs_cnt = 0; vs_row = -1; fcnt = 0;
        f_tot = m_tot; f_il = m_il; f_disp = m_disp; f_pos = m_pos; f_sw = m_sw;
      end
      if (ls) ln++;
      if (ls || hs) ev++;
      if (ls && vde) de_cnt++;
      if (ls && vsync) vs_cnt++;
      if (vsync && !vs_prev && vs_row < 0) vs_row = int'(raster);
      if (fs) fcnt++;
      vs_prev = int'(vsync);
    end
    if (run) begin
      ls = (ph == 0);
      hs = (ph == LP/2);
      ph = (ph + 1) % LP;
    end else begin
      ls = 0; hs = 0;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, input int exp, input string what);
    @(negedge clk); rd_addr = a; #1;
    chk(int'(rd_data) == exp, "R5", what, int'(rd_data), exp);
  endtask

  task automatic outputs_idle(input string req);
    chk(raster == 0 && field == 0, req, "raster/field idle", int'(raster), 0);
    chk(!vsync && !vde && !fs && !frs, req, "outputs idle", {int'(vsync), int'(vde), int'(fs), int'(frs)}, 0);
  endtask

  task automatic wait_to(input int n);
    while (frame_no < n) @(posedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    int f;
    repeat (3) @(negedge clk);
    outputs_idle("R1");
    rst_n = 1;
    repeat (4) @(negedge clk);
    outputs_idle("R1");

    wr(8'h0F, 8'hFF); rd(8'h0F, 8'h7F, "width reserved bit");
    wr(8'h13, 8'hFF); rd(8'h13, 8'h0F, "total high reserved bits");
    rd(8'h10, 0, "unmapped offset");
    wr(8'h0F, 8'd2); wr(8'h12, 8'd20); wr(8'h13, 8'd0);
    wr(8'h14, 8'd3); wr(8'h16, 8'd14);
    rd(8'h0F, 2, "width"); rd(8'h12, 20, "total low"); rd(8'h13, 0, "total high");
    rd(8'h14, 3, "position"); rd(8'h16, 14, "display");
    @(negedge clk);
    outputs_idle("R6");

    run = 1;
    @(posedge clk) prog_watch = 1;
    wait_to(3);
    repeat (40) @(negedge clk);
    f = frame_no;
    wr(8'h12, 8'd15); wr(8'h14, 8'd13); wr(8'h0F, 8'd4); wr(8'h16, 8'd15);
    wait_to(f + 1);
    chk(last_lines == 21, "R6", "frame during rewrite", last_lines, 21);
    wait_to(f + 2);
    chk(last_lines == 16, "R2", "frame after rewrite", last_lines, 16);
    wait_to(f + 3);
    @(posedge clk) prog_watch = 0;
    chk(prog_fld_hi == 0, "R9", "field high cycles in progressive", prog_fld_hi, 0);

    repeat (30) @(negedge clk);
    il = 1;
    @(posedge clk) r10_watch = 1;
    f = frame_no;
    wait_to(f + 1);
    r10_watch = 0;
    chk(r10_viol == 0, "R10", "odd field before frame start", r10_viol, 0);
    wait_to(f + 5);

    @(negedge clk) il = 0;
    f = frame_no;
    wait_to(f + 3);
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", frame_no, -1);
    summary();
    $finish;
  end
endmodule